// File: doc/BRIEF.md
# Integer Arithmetic-Logic Unit with Zero Detect

This block is the computation unit for a simple load/store processor datapath. It takes two 32-bit operands and a 4-bit operation selector. From them it produces a 32-bit result and a one-bit flag that is high whenever that result is all zeros. Six operations are defined: bitwise AND, bitwise OR, bitwise NOR, addition, subtraction, and signed set-less-than. Any other selector value gives a result of zero.

The unit is purely combinational. There is no clock, no reset and no stored state. The datapath uses the result for arithmetic results and memory addresses. It uses the zero flag after a subtraction to decide whether two registers are equal for a conditional branch. Additions and subtractions wrap around at 2^32 and never raise a trap.

Top module: `alu32_core`

## Requirements
- R1: Selector 4'b0000 gives the bitwise AND of the two operands.
- R2: Selector 4'b0001 gives the bitwise OR of the two operands.
- R3: Selector 4'b0010 gives the sum of the operands, taken modulo 2^32 with no overflow indication.
- R4: Selector 4'b0110 gives operand A minus operand B, taken modulo 2^32 with no overflow indication.
- R5: Selector 4'b0111 compares the operands as signed two's-complement values. The result is 1 in bit 0 when A < B and 0 otherwise, and bits 31..1 are always 0. This holds even when A - B overflows.
- R6: Selector 4'b1100 gives the bitwise NOR of the two operands.
- R7: The zero flag is 1 exactly when the 32-bit result of the selected operation is all zeros.
- R8: Each selector value not listed above (0011, 0100, 0101, 1000 to 1011, 1101 to 1111) gives a result of zero, and so the zero flag is 1.
- R9: Both outputs depend only on the present inputs. The same inputs give the same outputs whatever was applied before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First operand (A) |
| opnd_b | input | 32 | Second operand (B) |
| op_sel | input | 4 | Operation selector |
| result | output | 32 | Result of the selected operation |
| zero | output | 1 | High when result is all zeros |

## Verification
Both `result` and `zero` are due in the same cycle that the operands and selector are applied. No register lies between any input and any output, so the latency is zero cycles. The bench drives every stimulus just after a rising clock edge and samples both outputs at the following falling edge, half a period later. This leaves time for the inputs to settle and keeps each check away from the active edge. The R9 check applies one input set twice, with a different operation in between, and expects the same answer both times.

// File: rtl/alu32_pkg.sv
package alu32_pkg;
    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_AND  = 4'b0000,
        OP_OR   = 4'b0001,
        OP_ADD  = 4'b0010,
        OP_SUB  = 4'b0110,
        OP_SLT  = 4'b0111,
        OP_NOR  = 4'b1100
    } alu_op_e;

    function automatic logic op_is_defined(input logic [OP_W-1:0] code);
        return (code == OP_AND) || (code == OP_OR)  || (code == OP_ADD) ||
               (code == OP_SUB) || (code == OP_SLT) || (code == OP_NOR);
    endfunction
endpackage

// File: rtl/alu32_logic_unit.sv
module alu32_logic_unit #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] and_out,
    output logic [WIDTH-1:0] or_out,
    output logic [WIDTH-1:0] nor_out
);
    always_comb begin
        and_out = a_in & b_in;
        or_out  = a_in | b_in;
        nor_out = ~or_out;
    end
endmodule

// File: rtl/alu32_add_unit.sv
module alu32_add_unit #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             do_sub,
    output logic [WIDTH-1:0] sum_out,
    output logic             less_out
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic             ovf;

    always_comb begin
        b_eff    = do_sub ? ~b_in : b_in;
        sum_out  = a_in + b_eff + {{(WIDTH-1){1'b0}}, do_sub};
        // signed overflow of the difference: operand signs differ and
        // the difference sign differs from A
        ovf      = (a_in[MSB] != b_in[MSB]) && (sum_out[MSB] != a_in[MSB]);
        less_out = sum_out[MSB] ^ ovf;
    end
endmodule

// File: rtl/alu32_zero_detect.sv
module alu32_zero_detect #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] value_in,
    output logic             is_zero
);
    always_comb begin
        is_zero = ~|value_in;
    end
endmodule

// File: rtl/alu32_core.sv
module alu32_core #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0]              opnd_a,
    input  logic [WIDTH-1:0]              opnd_b,
    input  logic [alu32_pkg::OP_W-1:0]    op_sel,
    output logic [WIDTH-1:0]              result,
    output logic                          zero
);
    import alu32_pkg::*;

    logic [WIDTH-1:0] and_v;
    logic [WIDTH-1:0] or_v;
    logic [WIDTH-1:0] nor_v;
    logic [WIDTH-1:0] arith_v;
    logic             less_v;
    logic             sub_mode;

    // subtraction path also feeds the signed compare
    always_comb begin
        sub_mode = (op_sel == OP_SUB) || (op_sel == OP_SLT);
    end

    alu32_logic_unit #(.WIDTH(WIDTH)) u_logic (
        .a_in    (opnd_a),
        .b_in    (opnd_b),
        .and_out (and_v),
        .or_out  (or_v),
        .nor_out (nor_v)
    );

    alu32_add_unit #(.WIDTH(WIDTH)) u_add (
        .a_in     (opnd_a),
        .b_in     (opnd_b),
        .do_sub   (sub_mode),
        .sum_out  (arith_v),
        .less_out (less_v)
    );

    always_comb begin
        case (op_sel)
            OP_AND:  result = and_v;
            OP_OR:   result = or_v;
            OP_ADD:  result = arith_v;
            OP_SUB:  result = arith_v;
            OP_SLT:  result = {{(WIDTH-1){1'b0}}, less_v};
            OP_NOR:  result = nor_v;
            default: result = '0;
        endcase
    end

    alu32_zero_detect #(.WIDTH(WIDTH)) u_zero (
        .value_in (result),
        .is_zero  (zero)
    );
endmodule

// File: rtl/alu32_core_checker.sv
module alu32_core_checker #(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0]           opnd_a,
    input logic [WIDTH-1:0]           opnd_b,
    input logic [alu32_pkg::OP_W-1:0] op_sel,
    input logic [WIDTH-1:0]           result,
    input logic                       zero
);
    import alu32_pkg::*;

    always_comb begin
        // R7: a raised flag never accompanies a non-zero result
        a_r7_flag_implies_zero: assert (!zero || (result == '0));
        // R7: a zero result always raises the flag
        a_r7_zero_implies_flag: assert ((result != '0) || zero);
        // R5: compare leaves every bit above bit 0 clear
        a_r5_slt_upper_clear: assert ((op_sel != OP_SLT) || (result[WIDTH-1:1] == '0));
        // R8: unknown selectors give zero and raise the flag
        a_r8_undefined_zero: assert (op_is_defined(op_sel) || (result == '0 && zero));
        // R4: equal operands subtract to zero, so the flag rises
        a_r4_equal_sub_flag: assert ((op_sel != OP_SUB) || (opnd_a != opnd_b) || zero);
        // R3: adding zero returns operand A unchanged
        a_r3_add_identity: assert ((op_sel != OP_ADD) || (opnd_b != '0) || (result == opnd_a));
        // R6: NOR result has no bit set where either operand has one
        a_r6_nor_disjoint: assert ((op_sel != OP_NOR) || ((result & (opnd_a | opnd_b)) == '0));
    end
endmodule

bind alu32_core alu32_core_checker #(.WIDTH(WIDTH)) u_chk (
    .opnd_a (opnd_a),
    .opnd_b (opnd_b),
    .op_sel (op_sel),
    .result (result),
    .zero   (zero)
);

// File: tb/alu32_core_test.sv
module alu32_core_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;
    localparam int NVEC       = 20;

    // {selector, A, B, expected result}
    localparam logic [99:0] VEC [NVEC] = '{
        {4'b0000, 32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000}, // R1
        {4'b0000, 32'h12345678, 32'h00000000, 32'h00000000}, // R1
        {4'b0001, 32'h0F0F0000, 32'h00F0F00F, 32'h0FFFF00F}, // R2
        {4'b0001, 32'h00000000, 32'h00000000, 32'h00000000}, // R2
        {4'b0010, 32'h00000005, 32'h00000007, 32'h0000000C}, // R3
        {4'b0010, 32'hFFFFFFFF, 32'h00000001, 32'h00000000}, // R3 wrap
        {4'b0010, 32'h7FFFFFFF, 32'h00000001, 32'h80000000}, // R3 no trap
        {4'b0110, 32'h0000000A, 32'h00000003, 32'h00000007}, // R4
        {4'b0110, 32'h00000000, 32'h00000001, 32'hFFFFFFFF}, // R4 wrap
        {4'b0110, 32'h80000000, 32'h00000001, 32'h7FFFFFFF}, // R4 no trap
        {4'b0110, 32'h1234ABCD, 32'h1234ABCD, 32'h00000000}, // R4 equal
        {4'b0111, 32'hFFFFFFFF, 32'h00000001, 32'h00000001}, // R5 -1 < 1
        {4'b0111, 32'h00000001, 32'hFFFFFFFF, 32'h00000000}, // R5
        {4'b0111, 32'h80000000, 32'h7FFFFFFF, 32'h00000001}, // R5 overflow
        {4'b0111, 32'h7FFFFFFF, 32'h80000000, 32'h00000000}, // R5 overflow
        {4'b0111, 32'h00000005, 32'h00000005, 32'h00000000}, // R5 equal
        {4'b1100, 32'h00000000, 32'h00000000, 32'hFFFFFFFF}, // R6
        {4'b1100, 32'hF0F0F0F0, 32'h0F0F0F0F, 32'h00000000}, // R6
        {4'b1100, 32'h00FF00FF, 32'h0000FFFF, 32'hFF000000}, // R6
        {4'b0011, 32'hDEADBEEF, 32'h00000001, 32'h00000000}  // R8
    };

    logic        clk = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [3:0]  op_sel = '0;
    logic [31:0] result;
    logic        zero;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    alu32_core #(.WIDTH(32)) uut (
        .opnd_a (opnd_a),
        .opnd_b (opnd_b),
        .op_sel (op_sel),
        .result (result),
        .zero   (zero)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG && !done) begin
            n_fails++;
            $display("FAIL watchdog: actual %0d cycles, expected under %0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    // apply after a rising edge, sample at the falling edge (zero latency)
    task automatic apply_check(input logic [3:0] op, input logic [31:0] a,
                               input logic [31:0] b, input logic [31:0] exp_res,
                               input string req);
        @(posedge clk);
        op_sel = op;
        opnd_a = a;
        opnd_b = b;
        @(negedge clk);
        n_checks++;
        if (result !== exp_res) begin
            n_fails++;
            $display("FAIL %s result op=%b a=%h b=%h: actual %h expected %h",
                     req, op, a, b, result, exp_res);
        end
        // R7: flag follows the expected result
        if (zero !== (exp_res == 32'h0)) begin
            n_fails++;
            $display("FAIL R7 (%s) zero op=%b: actual %b expected %b",
                     req, op, zero, (exp_res == 32'h0));
        end
    endtask

    initial begin
        // initial inputs all zero: AND of zeros -> zero flag high (R1, R7)
        @(negedge clk);
        n_checks++;
        if (result !== 32'h0 || zero !== 1'b1) begin
            n_fails++;
            $display("FAIL R7 initial: actual %h/%b expected 00000000/1", result, zero);
        end

        for (int i = 0; i < NVEC; i++) begin
            apply_check(VEC[i][99:96], VEC[i][95:64], VEC[i][63:32], VEC[i][31:0], "vector");
        end

        // R8: every undefined selector with all-ones operands
        for (int c = 0; c < 16; c++) begin
            logic [3:0] code;
            code = 4'(c);
            if (code != 4'b0000 && code != 4'b0001 && code != 4'b0010 &&
                code != 4'b0110 && code != 4'b0111 && code != 4'b1100) begin
                apply_check(code, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0, "R8");
            end
        end

        // R5: most negative vs zero
        apply_check(4'b0111, 32'h80000000, 32'h00000000, 32'h00000001, "R5");
        // R4: max minus min wraps
        apply_check(4'b0110, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF, "R4");

        // R9: same inputs after different history give same answer
        apply_check(4'b0010, 32'h00000003, 32'h00000004, 32'h00000007, "R9");
        apply_check(4'b1100, 32'h00000000, 32'h00000000, 32'hFFFFFFFF, "R9");
        apply_check(4'b0010, 32'h00000003, 32'h00000004, 32'h00000007, "R9");

        finish_run();
    end
endmodule